// File: doc/BRIEF.md
# Synchronized Clock Output Shutdown Controller

This block takes a fast internal clock and divides it into one output clock phase. It drives that phase onto six gateable clock outputs and one feedback output that is never gated. Each gateable output is stopped by an active-low shutdown request. Outputs 0 and 1 share one request line, and outputs 2 to 5 each have a line of their own. A further active-low common request stops all six gateable outputs at once, and it leaves the feedback output running.

Every request comes from outside the clock domain, so it first passes through a multi-stage synchronizer. The gating state of an output may change only on the internal clock edge that starts a new output period. As a result, a high phase that has begun always completes at its full width. An output that is turned back on starts with a complete period, so no output ever shows a shortened pulse. A master output-enable input stands in for a three-state pad. When it is low, the per-pin drive-enable flags of all seven outputs are cleared. The clock values behind those flags keep running.

Top module: `clk_shutdown_ctrl`

## Requirements
- R1: A shutdown line at 0 holds its outputs LOW, and at 1 it lets them run. Line bit 0 controls outputs 0 and 1. Line bits 1, 2, 3 and 4 control outputs 2, 3, 4 and 5 in that order.
- R2: The common shutdown at 0 holds all six gated outputs LOW. The feedback output keeps toggling while it is 0.
- R3: The feedback output is high for HALF_CYC internal cycles and then low for HALF_CYC cycles, repeating without a break.
- R4: An enabled gated output carries the same value as the feedback output in every cycle.
- R5: Every high phase of a gated output lasts exactly HALF_CYC internal cycles. Every low phase lasts at least HALF_CYC cycles.
- R6: A gated output rises only in the cycle where the feedback output rises, and falls only in the cycle where the feedback output falls.
- R7: A request change passes through SYNC_STAGES flops before it can act. When an output is enabled, its first rising edge appears between SYNC_STAGES+1 and 2*HALF_CYC+SYNC_STAGES internal clock edges after the change.
- R8: Master output-enable at 0 clears all seven drive-enable flags, and at 1 it sets them. Bit 6 is the flag for the feedback output and bits 5 to 0 are the flags for the gated outputs. The output clock values are not affected.
- R9: While reset is low, every clock output and the feedback output are LOW. After reset is released, the feedback output goes high at the first edge while all gated outputs stay LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| out_en_i | input | 1 | Master output enable; 0 models high impedance on all pins |
| com_shut_n_i | input | 1 | Common active-low shutdown for the six gated outputs |
| shut_n_i | input | 5 | Per-group active-low shutdown lines |
| clk_o | output | 6 | Gated clock outputs |
| fb_o | output | 1 | Ungated feedback clock output |
| drv_en_o | output | 7 | Per-pin drive-enable flags; bit 6 is the feedback output |

## Verification
The assertions check on every cycle that a gated output rises only on a period boundary and falls only together with the feedback clock. They also check that a disabled output stays low after a boundary, that the common shutdown silences all six outputs, and that the feedback phases hold their width. Only the bench scenarios can show the remaining behaviour: that each shutdown line is mapped to the right outputs, that a request reaches an output within the synchronizer latency window, and that the drive-enable flags follow the master enable. They also show that, across many enable and disable sequences, no output ever has a high or low phase shorter than half a period.

// File: rtl/clk_shutdown_pkg.sv
package clk_shutdown_pkg;
    localparam int unsigned NUM_CLK = 6;
    localparam int unsigned NUM_GRP = 5;
    localparam int unsigned NUM_REQ = NUM_GRP + 1;
    localparam int unsigned COM_IDX = NUM_GRP;

    // Outputs 0 and 1 share request 0; every later output has its own line.
    function automatic int unsigned grp_of(input int unsigned idx);
        return (idx < 2) ? 0 : idx - 1;
    endfunction
endpackage

// File: rtl/clk_shutdown_sync.sv
module clk_shutdown_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] st;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.st[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.st[k] = s_q.st[k-1];
        end
    end

    // Reset to all-zero: every output starts shut down.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sync_o = s_q.st[STAGES-1];
endmodule

// File: rtl/clk_shutdown_phase.sv
module clk_shutdown_phase #(
    parameter int unsigned HALF_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic load_o,
    output logic high_nxt_o,
    output logic fb_o
);
    localparam int unsigned PERIOD = 2 * HALF_CYC;
    localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic [CW-1:0] ph;
        logic          fb;
    } phase_t;

    phase_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        load_o     = (s_q.ph == CW'(PERIOD - 1));
        s_d.ph     = load_o ? '0 : s_q.ph + CW'(1);
        high_nxt_o = (s_d.ph < CW'(HALF_CYC));
        s_d.fb     = high_nxt_o;
    end

    // Start on the last phase so the first edge opens a fresh period.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.ph <= CW'(PERIOD - 1);
            s_q.fb <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fb_o = s_q.fb;

    if (HALF_CYC > 1) begin : g_width_chk
        a_r3_fb_high_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(fb_o) |=> fb_o);
        a_r3_fb_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(fb_o) |=> !fb_o);
    end
endmodule

// File: rtl/clk_shutdown_gate.sv
module clk_shutdown_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic load_i,
    input  logic high_nxt_i,
    output logic clk_o
);
    typedef struct packed {
        logic gate;
        logic out;
    } gate_t;

    gate_t s_d, s_q;

    // The gate may only change at a period boundary, so a phase never gets cut.
    always_comb begin
        s_d      = s_q;
        s_d.gate = load_i ? en_i : s_q.gate;
        s_d.out  = s_d.gate & high_nxt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign clk_o = s_q.out;

    a_r1_off_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !en_i) |=> !clk_o);
    a_r6_rise_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_o) |-> $past(load_i));
endmodule

// File: rtl/clk_shutdown_ctrl.sv
module clk_shutdown_ctrl
    import clk_shutdown_pkg::*;
#(
    parameter int unsigned HALF_CYC    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               out_en_i,
    input  logic               com_shut_n_i,
    input  logic [NUM_GRP-1:0] shut_n_i,
    output logic [NUM_CLK-1:0] clk_o,
    output logic               fb_o,
    output logic [NUM_CLK:0]   drv_en_o
);
    logic [NUM_REQ-1:0] req_raw;
    logic [NUM_REQ-1:0] req_s;
    logic               load;
    logic               high_nxt;

    assign req_raw = {com_shut_n_i, shut_n_i};

    clk_shutdown_sync #(
        .WIDTH  (NUM_REQ),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (req_raw),
        .sync_o  (req_s)
    );

    clk_shutdown_phase #(
        .HALF_CYC (HALF_CYC)
    ) u_phase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_o     (load),
        .high_nxt_o (high_nxt),
        .fb_o       (fb_o)
    );

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_out
        localparam int unsigned GRP = grp_of(i);
        logic en;
        assign en = req_s[GRP] & req_s[COM_IDX];

        clk_shutdown_gate u_gate (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .en_i       (en),
            .load_i     (load),
            .high_nxt_i (high_nxt),
            .clk_o      (clk_o[i])
        );

        a_r6_fall_with_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(clk_o[i]) |-> $fell(fb_o));
    end

    // Models a three-state pad as a drive flag per pin; clock values are untouched.
    assign drv_en_o = {(NUM_CLK + 1){out_en_i}};

    a_r2_common_silences_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load && !req_s[COM_IDX]) |=> (clk_o == '0));
endmodule

// File: tb/clk_shutdown_ctrl_tb.sv
`timescale 1ns/1ps
module clk_shutdown_ctrl_tb;
    localparam int HALF   = 2;
    localparam int PERIOD = 2 * HALF;
    localparam int SYNC   = 2;

    typedef struct packed {
        logic [4:0] shut;
        logic       com;
        logic       oe;
        logic [5:0] exp_on;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{5'b11111, 1'b1, 1'b1, 6'b111111},
        '{5'b11110, 1'b1, 1'b1, 6'b111100},
        '{5'b00001, 1'b1, 1'b1, 6'b000011},
        '{5'b10101, 1'b1, 1'b0, 6'b101011},
        '{5'b11111, 1'b0, 1'b1, 6'b000000},
        '{5'b01010, 1'b1, 1'b1, 6'b010100},
        '{5'b11111, 1'b1, 1'b1, 6'b111111}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_en = 1'b1;
    logic       com_n = 1'b1;
    logic [4:0] shut_n = 5'b11111;
    logic [5:0] clk_o;
    logic       fb_o;
    logic [6:0] drv_en;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  mon_on = 1'b0;

    always #2 clk = ~clk;

    clk_shutdown_ctrl #(.HALF_CYC(HALF), .SYNC_STAGES(SYNC)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .out_en_i     (out_en),
        .com_shut_n_i (com_n),
        .shut_n_i     (shut_n),
        .clk_o        (clk_o),
        .fb_o         (fb_o),
        .drv_en_o     (drv_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Phase-width monitor on all seven outputs (bit 6 = feedback).
    logic [6:0] prev;
    int         len [7];
    bit         seen [7];
    always @(negedge clk) begin
        if (mon_on) begin
            logic [6:0] cur;
            cur = {fb_o, clk_o};
            for (int i = 0; i < 7; i++) begin
                if (cur[i] != prev[i]) begin
                    if (seen[i]) begin
                        if (i == 6)
                            chk(len[i] == HALF, "R3 feedback phase width", len[i], HALF);
                        else if (prev[i])
                            chk(len[i] == HALF, "R5 gated high width", len[i], HALF);
                        else
                            chk(len[i] >= HALF, "R5 gated low width", len[i], HALF);
                    end
                    if (i < 6)
                        chk(cur[6] != prev[6] && cur[6] == cur[i],
                            "R6 gated edge with feedback edge", int'(cur[6]), int'(cur[i]));
                    seen[i] = 1'b1;
                    len[i]  = 1;
                end else begin
                    len[i]++;
                end
            end
            prev = cur;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(clk_o == 6'b0, "R9 gated outputs low in reset", int'(clk_o), 0);
        chk(fb_o == 1'b0, "R9 feedback low in reset", int'(fb_o), 0);
        chk(drv_en == 7'h7f, "R8 flags set with enable high", int'(drv_en), 'h7f);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fb_o == 1'b1, "R9 feedback high after first edge", int'(fb_o), 1);
        chk(clk_o == 6'b0, "R9 gated outputs still low", int'(clk_o), 0);
        prev   = {fb_o, clk_o};
        for (int i = 0; i < 7; i++) begin
            seen[i] = 1'b0;
            len[i]  = 1;
        end
        mon_on = 1'b1;

        // Vector table: R1 R2 R4 R8
        for (int v = 0; v < NV; v++) begin
            shut_n = VECS[v].shut;
            com_n  = VECS[v].com;
            out_en = VECS[v].oe;
            repeat (3 * PERIOD + 4) @(negedge clk);
            chk(drv_en == {7{VECS[v].oe}}, "R8 drive flags follow enable",
                int'(drv_en), int'({7{VECS[v].oe}}));
            for (int s = 0; s < 2 * PERIOD; s++) begin
                @(negedge clk);
                chk(clk_o == (VECS[v].exp_on & {6{fb_o}}), "R1 R4 output pattern",
                    int'(clk_o), int'(VECS[v].exp_on & {6{fb_o}}));
            end
        end

        // R2: feedback keeps running under common shutdown
        begin
            int   rises;
            logic p;
            com_n  = 1'b0;
            shut_n = 5'b11111;
            repeat (3 * PERIOD + 4) @(negedge clk);
            rises = 0;
            p     = fb_o;
            for (int s = 0; s < 2 * PERIOD; s++) begin
                @(negedge clk);
                if (fb_o && !p) rises++;
                chk(clk_o == 6'b0, "R2 gated outputs held low", int'(clk_o), 0);
                p = fb_o;
            end
            chk(rises == 2, "R2 feedback rises under common shutdown", rises, 2);
        end

        // R7: enable latency through the synchronizer
        begin
            int k;
            com_n  = 1'b1;
            shut_n = 5'b00000;
            repeat (3 * PERIOD + 4) @(negedge clk);
            shut_n[1] = 1'b1;
            k = 0;
            while (k < 40) begin
                @(negedge clk);
                k++;
                if (clk_o[2]) break;
            end
            chk(k >= SYNC + 1 && k <= PERIOD + SYNC, "R7 enable latency",
                k, PERIOD + SYNC);
            chk(clk_o == 6'b000100, "R7 only output 2 woke", int'(clk_o), 'b000100);
        end

        // R8: flags clear while clocks keep running
        begin
            int   rises;
            logic p;
            out_en = 1'b0;
            rises  = 0;
            p      = fb_o;
            for (int s = 0; s < 2 * PERIOD; s++) begin
                @(negedge clk);
                if (clk_o[2] && !p) rises++;
                p = clk_o[2];
            end
            chk(drv_en == 7'h00, "R8 flags cleared", int'(drv_en), 0);
            chk(rises >= 1, "R8 clock runs with pins disabled", rises, 1);
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule